// File: doc/BRIEF.md
# Masked Data Watchpoint Comparator

This block watches the load and store traffic of a processor pipeline and raises a debug break when an access touches a guarded memory region. It holds a parameterised number of watchpoint slots. Each slot has a base-address register and a control register. The control register carries two arming bits, one for reads and one for writes, and a mask field. The mask field selects which low address bits are ignored, so a slot guards an aligned region whose size is a power of two bytes.

Software programs the slots through a single write port. The pipeline presents each access as one cycle of `acc_valid`, together with the address and a store flag. If any armed slot covers the address, the block raises `brk_hit` on the following cycle, before the access is allowed to complete, and reports the number of the slot that matched. When more than one slot matches, the lowest-numbered slot is reported. What the core does after the break is outside this block.

A mask field whose ones do not form one unbroken run starting at its top bit is repaired before it is used. The leading run of ones is kept and every bit below the first zero is treated as zero. The watched region is therefore always aligned and contiguous.

Top module: `dbw_unit`

## Requirements
- R1: When reset is released, every slot is disarmed and `brk_hit` is 0. A reset in mid-operation clears slots that were armed before it.
- R2: Control bit 1 arms a slot for stores. A slot armed only for stores matches store accesses and never matches load accesses.
- R3: Control bit 0 arms a slot for loads. A slot armed only for loads matches load accesses and never matches store accesses.
- R4: A slot with both arming bits clear never matches, whatever its address and mask.
- R5: Control bits [8+MASK_W-1:8] hold the mask field, and mask bit k corresponds to address bit k. The effective mask is this field with all address bits above it forced to one. An access matches when the address and the base, both ANDed with the effective mask, are equal. Addresses just outside the region, and addresses that differ only in the upper bits, do not match.
- R6: If the mask field is not contiguous, only the unbroken run of ones that starts at its most significant bit is used. Every lower bit of the field counts as zero.
- R7: When several slots match the same access, `brk_idx` reports the lowest slot number. `brk_idx` is 0 whenever `brk_hit` is 0.
- R8: `brk_hit` and `brk_idx` are registered. They reflect the access presented with `acc_valid` high in the previous cycle, and `brk_hit` is 0 in any cycle that follows a cycle with `acc_valid` low.
- R9: A write with `cfg_we` high loads `cfg_wdata` into slot `cfg_idx`. It goes to the base register when `cfg_sel` is 0 and to the control register when `cfg_sel` is 1, and it takes effect for accesses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W | Slot selected for the write |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Byte address of the access |
| brk_hit | output | 1 | Break request for the access of the previous cycle |
| brk_idx | output | IDX_W | Lowest matching slot |

## Verification
The bench probes the first and last byte of each region and the byte just past each end. A wrong mask width or a swapped comparison polarity shows up there as a break outside the region, or as a missing break inside it. One slot is given a broken mask, and the probe address is chosen to match only after the mask has been repaired. A design that uses the raw mask therefore stays silent at that address. An address covered by two slots checks the priority order, since an encoder that favours the higher slot reports the wrong index. The bench also swaps the access type on a single-direction slot, presents an address with `acc_valid` low, and resets in mid-run; the first exposes crossed arming bits, the second a missing valid qualifier, the third control state that survives reset.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    // Control register layout
    localparam int CTL_LD_BIT   = 0;
    localparam int CTL_ST_BIT   = 1;
    localparam int CTL_MASK_LSB = 8;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_CTL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic st;
        logic ld;
    } arm_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dbw_regs.sv
module dbw_regs
    import dbw_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_q  [NUM_WP],
    output logic [MASK_W-1:0] field_q [NUM_WP],
    output arm_t              arm_q   [NUM_WP]
);

    for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
        logic sel_this;
        assign sel_this = cfg_we && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                field_q[g] <= '0;
                arm_q[g]   <= '0;
            end else if (sel_this) begin
                if (reg_sel_e'(cfg_sel) == SEL_BASE) begin
                    base_q[g] <= cfg_wdata;
                end else begin
                    field_q[g]  <= cfg_wdata[CTL_MASK_LSB +: MASK_W];
                    arm_q[g].ld <= cfg_wdata[CTL_LD_BIT];
                    arm_q[g].st <= cfg_wdata[CTL_ST_BIT];
                end
            end
        end
    end

endmodule

// File: rtl/dbw_cmp.sv
module dbw_cmp
    import dbw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [MASK_W-1:0] field,
    input  arm_t              arm,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    output logic              hit
);

    localparam int HI_W = ADDR_W - MASK_W;

    logic [MASK_W-1:0] field_fix;
    logic [ADDR_W-1:0] eff_mask;
    logic              kind_ok;

    // Keep only the unbroken run of ones from the top of the field
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            run          = run & field[i];
            field_fix[i] = run;
        end
    end

    if (HI_W > 0) begin : g_pad
        assign eff_mask = {{HI_W{1'b1}}, field_fix};
    end else begin : g_nopad
        assign eff_mask = field_fix;
    end

    assign kind_ok = acc_store ? arm.st : arm.ld;
    assign hit     = kind_ok && (((acc_addr ^ base) & eff_mask) == '0);

endmodule

// File: rtl/dbw_prio.sv
module dbw_prio #(
    parameter int NUM_WP = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_WP-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_WP - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/dbw_unit.sv
module dbw_unit
    import dbw_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    localparam int IDX_W = idx_width(NUM_WP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              brk_hit,
    output logic [IDX_W-1:0]  brk_idx
);

    logic [ADDR_W-1:0] base_q  [NUM_WP];
    logic [MASK_W-1:0] field_q [NUM_WP];
    arm_t              arm_q   [NUM_WP];
    logic [NUM_WP-1:0] slot_hit;
    logic [NUM_WP-1:0] arm_ld_vec;
    logic [NUM_WP-1:0] arm_st_vec;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;

    dbw_regs #(
        .NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .field_q   (field_q),
        .arm_q     (arm_q)
    );

    for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
        dbw_cmp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_cmp (
            .base      (base_q[g]),
            .field     (field_q[g]),
            .arm       (arm_q[g]),
            .acc_addr  (acc_addr),
            .acc_store (acc_store),
            .hit       (slot_hit[g])
        );
        assign arm_ld_vec[g] = arm_q[g].ld;
        assign arm_st_vec[g] = arm_q[g].st;
    end

    dbw_prio #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_prio (
        .req (slot_hit),
        .any (any_hit),
        .idx (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_hit <= 1'b0;
            brk_idx <= '0;
        end else begin
            brk_hit <= acc_valid && any_hit;
            brk_idx <= (acc_valid && any_hit) ? win_idx : '0;
        end
    end

endmodule

// File: rtl/dbw_unit_chk.sv
module dbw_unit_chk #(
    parameter int NUM_WP = 4,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_store,
    input logic [NUM_WP-1:0] arm_ld,
    input logic [NUM_WP-1:0] arm_st,
    input logic              brk_hit,
    input logic [IDX_W-1:0]  brk_idx
);

    // R1: reset leaves no break pending
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !brk_hit);

    // R8: a break only follows a valid access
    a_r8_hit_needs_access: assert property (@(posedge clk) disable iff (rst)
        brk_hit |-> $past(acc_valid));

    // R2: no store slot armed, so a store cannot break
    a_r2_store_unarmed: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_store && arm_st == '0) |=> !brk_hit);

    // R3: no load slot armed, so a load cannot break
    a_r3_load_unarmed: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_store && arm_ld == '0) |=> !brk_hit);

    // R7: reported index is a real slot, and zero when idle
    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        brk_hit |-> (int'(brk_idx) < NUM_WP));

    a_r7_idle_idx_zero: assert property (@(posedge clk) disable iff (rst)
        !brk_hit |-> (brk_idx == '0));

endmodule

bind dbw_unit dbw_unit_chk #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_store (acc_store),
    .arm_ld    (arm_ld_vec),
    .arm_st    (arm_st_vec),
    .brk_hit   (brk_hit),
    .brk_idx   (brk_idx)
);

// File: tb/dbw_unit_test.sv
module dbw_unit_test;

    localparam int NUM_WP = 4;
    localparam int ADDR_W = 32;
    localparam int MASK_W = 6;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic              cfg_sel = 1'b0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              acc_valid = 1'b0;
    logic              acc_store = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              brk_hit;
    logic [IDX_W-1:0]  brk_idx;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dbw_unit #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) uut (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_sel, .cfg_wdata,
        .acc_valid, .acc_store, .acc_addr, .brk_hit, .brk_idx
    );

    // {addr, store, expected hit, expected index}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {32'h0000_1000, 1'b1, 1'b1, 2'd0},  // R2 store slot 0
        {32'h0000_1000, 1'b0, 1'b0, 2'd0},  // R2 load ignored by slot 0
        {32'h0000_1003, 1'b1, 1'b1, 2'd0},  // R7 slots 0 and 1 both match
        {32'h0000_1003, 1'b0, 1'b1, 2'd1},  // R3 only slot 1 loads
        {32'h0000_1004, 1'b1, 1'b0, 2'd0},  // R5 one past end
        {32'h0000_0FFF, 1'b1, 1'b0, 2'd0},  // R5 one before start
        {32'h0000_2025, 1'b0, 1'b1, 2'd2},  // R6 repaired mask
        {32'h0000_2025, 1'b1, 1'b0, 2'd0},  // R3 store ignored by load slot
        {32'h0000_201F, 1'b0, 1'b0, 2'd0},  // R6 below region
        {32'h0000_203F, 1'b0, 1'b1, 2'd2},  // R6 last byte
        {32'h0000_3000, 1'b0, 1'b0, 2'd0},  // R4 disarmed slot
        {32'h0000_3000, 1'b1, 1'b0, 2'd0},  // R4 disarmed slot
        {32'h0001_1000, 1'b1, 1'b0, 2'd0}   // R5 upper bits differ
    };

    task automatic check(input string req, input logic exp_hit,
                         input logic [IDX_W-1:0] exp_idx);
        n_checks++;
        if (brk_hit !== exp_hit || brk_idx !== exp_idx) begin
            n_errors++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     req, brk_hit, brk_idx, exp_hit, exp_idx);
        end
    endtask

    task automatic wr(input int idx, input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic st, input logic v);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_store = st;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic program_slots();
        wr(0, 1'b0, 32'h0000_1000); wr(0, 1'b1, 32'h0000_3C02);
        wr(1, 1'b0, 32'h0000_1002); wr(1, 1'b1, 32'h0000_3E03);
        wr(2, 1'b0, 32'h0000_2030); wr(2, 1'b1, 32'h0000_2F01);
        wr(3, 1'b0, 32'h0000_3000); wr(3, 1'b1, 32'h0000_3F00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 1'b0, '0);
        access(32'h0, 1'b0, 1'b1);
        check("R1 disarmed after reset", 1'b0, '0);

        program_slots();
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][35:4], VEC[i][3], 1'b1);
            check($sformatf("R5 vector %0d", i), VEC[i][2], VEC[i][1:0]);
        end

        // R8: no valid, no break; pulse lasts one cycle
        access(32'h0000_1000, 1'b1, 1'b0);
        check("R8 valid low", 1'b0, '0);
        access(32'h0000_1000, 1'b1, 1'b1);
        check("R8 registered hit", 1'b1, 2'd0);
        @(negedge clk);
        check("R8 one cycle only", 1'b0, '0);

        // R9: arm slot 3 for loads with a full mask
        wr(3, 1'b1, 32'h0000_3F01);
        access(32'h0000_3000, 1'b0, 1'b1);
        check("R9 control write", 1'b1, 2'd3);
        access(32'h0000_3001, 1'b0, 1'b1);
        check("R9 one byte region", 1'b0, '0);
        // R9: move slot 0 base
        wr(0, 1'b0, 32'h0000_5000);
        access(32'h0000_5002, 1'b1, 1'b1);
        check("R9 base write", 1'b1, 2'd0);

        // R1: reset mid-run clears armed slots
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(32'h0000_5002, 1'b1, 1'b1);
        check("R1 reset clears slot", 1'b0, '0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule